// File: doc/BRIEF.md
# Inset Sync Decimation Window Generator

This block sits at the input of the inset (small-picture) path and runs on the 27 MHz sampling clock. It takes horizontal and vertical sync pulses of the inset source that have already been sampled, and it counts positions on a 13.5 MHz clock-enable. From these it produces a single flag that marks the part of the active picture the downstream filters and sub-samplers should use. The same sync analysis tells the 625-line standard from the 525-line standard and removes spurious vertical pulses. It also reports whether the current field is the odd or the even one.

A programmable horizontal delay shifts the window so that the picture can be centred. A programmable vertical delay sets the phase of the vertical reference. The horizontal delay also adds to that phase, and a source that supplies combined three-level sync gets an extra fixed vertical delay. The field parity is only meaningful when that phase places the reference pulse in the correct half of a line. A decoded colour-system code, together with a register bit, drives the chroma gain select.

Top module: `isw_inset_window`

## Requirements
- R1: While reset is asserted, and after reset until the first accepted vertical reference, `win_o` is 0. During reset `std525_o` (when auto mode is on) and `field_odd_o` are 0.
- R2: The pixel position is the number of `ce13_i` ticks since the last `hsync_i` pulse. In a window line with `hdelay_i` = 0, `win_o` is high from position HOPEN_BASE (104 by default) for WIN_TICKS ticks.
- R3: A non-zero `hdelay_i` moves both the opening and the closing of the window later by `hdelay_i` ticks.
- R4: Lines are numbered by counting `hsync_i` pulses after the accepted vertical reference. Window lines start at FIRST_LINE_625 (36) in the 625-line standard and at FIRST_LINE_525 (26) in the 525-line standard. They span WIN_LINES_625 or WIN_LINES_525 lines respectively.
- R5: A delayed vertical pulse that arrives fewer than MIN_VS_GAP lines after the previous accepted one is ignored. Line numbering, the window and the standard measurement all continue unchanged.
- R6: Each accepted reference after the first measures the field length in half-lines. This is twice the line count, plus 1 if the pulse fell in the second half of a line. A value below STD_THRESH_HALF means 525 lines, encoded as 1; otherwise it means 625 lines, encoded as 0. The detected standard changes only when two consecutive measurements agree.
- R7: With `std_auto_i` = 0, `std525_o` follows `std_force525_i` at once, and the window uses that standard.
- R8: The vertical reference is taken `vdelay_i` + `hdelay_i` ticks after `vsync_i`. It is taken a further COMB_EXTRA ticks later when `sync_combined_i` = 1.
- R9: At each accepted reference, `field_odd_o` becomes 0 if the pixel position is below half the previous line length, and 1 otherwise.
- R10: `chroma_x2_o` is 1 when `sys_code_i` = 2'b10 (SECAM) or `chroma_x2_i` = 1. The codes 2'b00 (PAL), 2'b01 (NTSC) and 2'b11 give no gain on their own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 27 MHz sampling clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| ce13_i | input | 1 | 13.5 MHz counting enable |
| hsync_i | input | 1 | Sampled inset horizontal sync, one-cycle pulse |
| vsync_i | input | 1 | Sampled inset vertical sync, one-cycle pulse |
| sync_combined_i | input | 1 | Sync comes from the combined three-level input |
| hdelay_i | input | HDEL_W | Horizontal window delay in ticks |
| vdelay_i | input | VDEL_W | Vertical reference delay in ticks |
| std_auto_i | input | 1 | 1 = detect line standard automatically |
| std_force525_i | input | 1 | Standard used when auto is off (1 = 525) |
| sys_code_i | input | 2 | Decoded colour-system select |
| chroma_x2_i | input | 1 | Register request for chroma gain of 2 |
| win_o | output | 1 | Decimation window flag |
| std525_o | output | 1 | Line standard in use (1 = 525) |
| field_odd_o | output | 1 | Field parity of the last accepted reference |
| chroma_x2_o | output | 1 | Chroma gain-of-2 select |

## Verification
The hardest situation to reach is a change of the detected standard. It needs an uninterrupted run of fields: one field of the new length gives a candidate, and a second agreeing field makes the change. This must happen while noise pulses, shifted phases and delayed references are in play and must not disturb the count. The stimulus is a table of consecutive fields with 31 or 26 lines, each with its own pulse position, delays and optional extra pulse. Walking the table in order steps the detector from 625 to a lone 525 candidate, then to 525, then back again. After every field, the bench checks the window placement of each line together with the standard and the parity.

// File: rtl/isw_pkg.sv
package isw_pkg;

    typedef enum logic [1:0] {
        SYS_PAL   = 2'b00,
        SYS_NTSC  = 2'b01,
        SYS_SECAM = 2'b10,
        SYS_RSVD  = 2'b11
    } sys_t;

    typedef enum logic {
        STD_625 = 1'b0,
        STD_525 = 1'b1
    } lstd_t;

endpackage

// File: rtl/isw_hcount.sv
module isw_hcount #(
    parameter int PIX_W = 11
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             ce_i,
    input  logic             hs_i,
    output logic [PIX_W-1:0] pix_o,
    output logic             half_o
);

    typedef struct packed {
        logic [PIX_W-1:0] pix;
        logic [PIX_W-1:0] len;
    } hc_t;

    hc_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (hs_i) begin
            st_d.len = st_q.pix;
            st_d.pix = '0;
        end else if (ce_i && (st_q.pix != '1)) begin
            st_d.pix = st_q.pix + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign pix_o  = st_q.pix;
    assign half_o = (st_q.pix >= (st_q.len >> 1));

    // R2: each line restarts the tick position
    a_r2_pix_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hs_i |=> (pix_o == '0));

    // R2: the position only moves on a counting tick
    a_r2_pix_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!hs_i && !ce_i) |=> $stable(pix_o));

endmodule

// File: rtl/isw_vdelay.sv
module isw_vdelay #(
    parameter int DLY_W = 13
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             ce_i,
    input  logic             vs_i,
    input  logic [DLY_W-1:0] dly_i,
    output logic             vs_dly_o
);

    typedef struct packed {
        logic             pend;
        logic [DLY_W-1:0] cnt;
    } vd_t;

    vd_t  st_d, st_q;
    logic fire;

    assign fire = st_q.pend && (st_q.cnt == '0);

    always_comb begin
        st_d = st_q;
        if (vs_i) begin
            st_d.pend = 1'b1;
            st_d.cnt  = dly_i;
        end else if (fire) begin
            st_d.pend = 1'b0;
        end else if (st_q.pend && ce_i) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign vs_dly_o = fire;

    // R8: one input pulse gives one delayed pulse
    a_r8_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (vs_dly_o && !vs_i) |=> !vs_dly_o);

    // R8: the delay is measured in counting ticks only
    a_r8_hold_between_ticks: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.pend && !vs_i && !ce_i) |=> $stable(st_q.cnt));

endmodule

// File: rtl/isw_vref.sv
module isw_vref
    import isw_pkg::*;
#(
    parameter int LINE_W          = 10,
    parameter int MIN_VS_GAP      = 200,
    parameter int STD_THRESH_HALF = 575
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              hs_i,
    input  logic              vs_dly_i,
    input  logic              half_i,
    output logic [LINE_W-1:0] line_o,
    output logic              seen_o,
    output logic              det525_o,
    output logic              odd_o
);

    localparam int HC_W = LINE_W + 1;

    typedef struct packed {
        logic [LINE_W-1:0] line;
        logic              seen;
        lstd_t             det;
        lstd_t             cand;
        logic              cand_v;
        logic              odd;
    } vr_t;

    vr_t             st_d, st_q;
    logic            acc;
    logic [HC_W-1:0] half_cnt;
    lstd_t           meas;

    assign acc      = vs_dly_i && (!st_q.seen || (st_q.line >= LINE_W'(MIN_VS_GAP)));
    assign half_cnt = {st_q.line, half_i};
    assign meas     = (half_cnt < HC_W'(STD_THRESH_HALF)) ? STD_525 : STD_625;

    always_comb begin
        st_d = st_q;
        if (hs_i && (st_q.line != '1)) begin
            st_d.line = st_q.line + 1'b1;
        end
        if (acc) begin
            st_d.line = '0;
            st_d.seen = 1'b1;
            st_d.odd  = half_i;
            if (st_q.seen) begin
                st_d.cand   = meas;
                st_d.cand_v = 1'b1;
                if (st_q.cand_v && (st_q.cand == meas)) begin
                    st_d.det = meas;
                end
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '{line: '0, seen: 1'b0, det: STD_625, cand: STD_625,
                      cand_v: 1'b0, odd: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign line_o   = st_q.line;
    assign seen_o   = st_q.seen;
    assign det525_o = (st_q.det == STD_525);
    assign odd_o    = st_q.odd;

    // R5: an accepted reference restarts line numbering
    a_r5_line_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
        acc |=> (line_o == '0));

    // R6: the detected standard moves only on an accepted reference
    a_r6_std_on_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !acc |=> $stable(st_q.det));

    // R9: parity moves only on an accepted reference
    a_r9_parity_on_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !acc |=> $stable(odd_o));

endmodule

// File: rtl/isw_inset_window.sv
module isw_inset_window
    import isw_pkg::*;
#(
    parameter int PIX_W           = 11,
    parameter int LINE_W          = 10,
    parameter int HDEL_W          = 8,
    parameter int VDEL_W          = 8,
    parameter int HOPEN_BASE      = 104,
    parameter int WIN_TICKS       = 704,
    parameter int FIRST_LINE_625  = 36,
    parameter int FIRST_LINE_525  = 26,
    parameter int WIN_LINES_625   = 264,
    parameter int WIN_LINES_525   = 228,
    parameter int STD_THRESH_HALF = 575,
    parameter int MIN_VS_GAP      = 200,
    parameter int COMB_EXTRA      = 216
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              ce13_i,
    input  logic              hsync_i,
    input  logic              vsync_i,
    input  logic              sync_combined_i,
    input  logic [HDEL_W-1:0] hdelay_i,
    input  logic [VDEL_W-1:0] vdelay_i,
    input  logic              std_auto_i,
    input  logic              std_force525_i,
    input  logic [1:0]        sys_code_i,
    input  logic              chroma_x2_i,
    output logic              win_o,
    output logic              std525_o,
    output logic              field_odd_o,
    output logic              chroma_x2_o
);

    localparam int HW    = PIX_W + 2;
    localparam int LW    = LINE_W + 1;
    localparam int DLY_W = PIX_W + 2;

    logic [PIX_W-1:0]  pix;
    logic              half;
    logic              vs_dly;
    logic [LINE_W-1:0] line;
    logic              seen;
    logic              det525;
    logic [DLY_W-1:0]  dly_total;
    logic [HW-1:0]     h_open, h_close, pix_x;
    logic [LW-1:0]     v_first, v_end, line_x;
    logic              hact, vact;

    always_comb begin
        dly_total = DLY_W'(vdelay_i) + DLY_W'(hdelay_i)
                  + (sync_combined_i ? DLY_W'(COMB_EXTRA) : DLY_W'(0));
    end

    isw_hcount #(.PIX_W(PIX_W)) hcount_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .ce_i   (ce13_i),
        .hs_i   (hsync_i),
        .pix_o  (pix),
        .half_o (half)
    );

    isw_vdelay #(.DLY_W(DLY_W)) vdelay_i0 (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .ce_i     (ce13_i),
        .vs_i     (vsync_i),
        .dly_i    (dly_total),
        .vs_dly_o (vs_dly)
    );

    isw_vref #(
        .LINE_W          (LINE_W),
        .MIN_VS_GAP      (MIN_VS_GAP),
        .STD_THRESH_HALF (STD_THRESH_HALF)
    ) vref_i (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .hs_i     (hsync_i),
        .vs_dly_i (vs_dly),
        .half_i   (half),
        .line_o   (line),
        .seen_o   (seen),
        .det525_o (det525),
        .odd_o    (field_odd_o)
    );

    always_comb begin
        std525_o = std_auto_i ? det525 : std_force525_i;

        pix_x   = HW'(pix);
        h_open  = HW'(HOPEN_BASE) + HW'(hdelay_i);
        h_close = h_open + HW'(WIN_TICKS);
        hact    = (pix_x >= h_open) && (pix_x < h_close);

        line_x  = LW'(line);
        v_first = std525_o ? LW'(FIRST_LINE_525) : LW'(FIRST_LINE_625);
        v_end   = v_first + (std525_o ? LW'(WIN_LINES_525) : LW'(WIN_LINES_625));
        vact    = seen && (line_x >= v_first) && (line_x < v_end);

        win_o       = hact && vact;
        chroma_x2_o = (sys_t'(sys_code_i) == SYS_SECAM) || chroma_x2_i;
    end

    // R2: with delay and standard steady, the window opens only on a tick
    a_r2_open_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($rose(win_o) && $stable(hdelay_i) && $stable(std525_o)) |-> $past(ce13_i));

    // R1: no window before the first reference
    a_r1_no_window_unsynced: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !seen |-> !win_o);

endmodule

// File: tb/isw_inset_window_tb_top.sv
module isw_inset_window_tb_top;

    localparam int HB    = 10;
    localparam int WW    = 12;
    localparam int F625  = 6;
    localparam int N625  = 4;
    localparam int F525  = 4;
    localparam int N525  = 3;
    localparam int STEPS = 64;   // 32 counting ticks per line

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst_n, ce, hs, vs, cmb, auto_en, force525, gain_reg;
    logic [7:0] hd, vd;
    logic [1:0] sys;
    logic       win, std525, fodd, gain;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    int wcnt   [STEPS];
    int wfirst [STEPS];

    typedef struct packed {
        logic [5:0] nl;     // lines in field
        logic [5:0] vst;    // tick of vertical pulse in line 0
        logic [5:0] noise;  // line of extra pulse, 0 = none
        logic [7:0] hdl;
        logic [7:0] vdl;
        logic       cmb;
        logic       std;    // expected standard after this field's reference
        logic       par;    // expected parity
    } fld_t;

    localparam fld_t FIELDS [12] = '{
        '{6'd31, 6'd5,  6'd0, 8'd0, 8'd0,  1'b0, 1'b0, 1'b0},  // first reference
        '{6'd31, 6'd5,  6'd3, 8'd0, 8'd0,  1'b0, 1'b0, 1'b0},  // R5 noise pulse
        '{6'd26, 6'd5,  6'd0, 8'd0, 8'd0,  1'b0, 1'b0, 1'b0},  // 625 confirmed
        '{6'd26, 6'd5,  6'd0, 8'd3, 8'd0,  1'b0, 1'b0, 1'b0},  // single 525 candidate
        '{6'd26, 6'd5,  6'd0, 8'd3, 8'd0,  1'b0, 1'b1, 1'b0},  // 525 confirmed
        '{6'd26, 6'd20, 6'd0, 8'd0, 8'd0,  1'b0, 1'b1, 1'b1},  // R9 second half
        '{6'd26, 6'd5,  6'd0, 8'd0, 8'd0,  1'b1, 1'b1, 1'b1},  // R8 combined extra
        '{6'd26, 6'd5,  6'd0, 8'd0, 8'd12, 1'b0, 1'b1, 1'b1},  // R8 vertical delay
        '{6'd26, 6'd7,  6'd0, 8'd9, 8'd0,  1'b0, 1'b1, 1'b1},  // R3 hdelay shifts phase
        '{6'd31, 6'd5,  6'd0, 8'd0, 8'd0,  1'b0, 1'b1, 1'b0},
        '{6'd31, 6'd5,  6'd0, 8'd0, 8'd0,  1'b0, 1'b1, 1'b0},  // single 625 candidate
        '{6'd31, 6'd5,  6'd0, 8'd0, 8'd0,  1'b0, 1'b0, 1'b0}   // back to 625
    };

    isw_inset_window #(
        .HOPEN_BASE      (HB),
        .WIN_TICKS       (WW),
        .FIRST_LINE_625  (F625),
        .FIRST_LINE_525  (F525),
        .WIN_LINES_625   (N625),
        .WIN_LINES_525   (N525),
        .STD_THRESH_HALF (57),
        .MIN_VS_GAP      (20),
        .COMB_EXTRA      (16)
    ) dut_i (
        .clk_i           (clk),
        .rst_ni          (rst_n),
        .ce13_i          (ce),
        .hsync_i         (hs),
        .vsync_i         (vs),
        .sync_combined_i (cmb),
        .hdelay_i        (hd),
        .vdelay_i        (vd),
        .std_auto_i      (auto_en),
        .std_force525_i  (force525),
        .sys_code_i      (sys),
        .chroma_x2_i     (gain_reg),
        .win_o           (win),
        .std525_o        (std525),
        .field_odd_o     (fodd),
        .chroma_x2_o     (gain)
    );

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input int line, input int s, input logic h, input logic v);
        @(negedge clk);
        if (s != 0 && win) begin
            wcnt[line]++;
            if (wfirst[line] < 0) wfirst[line] = s;
        end
        hs = h;
        vs = v;
        ce = ((s % 2) == 1);
    endtask

    task automatic run_field(input fld_t f, input int idx);
        int bad = 0;
        int fl, nw, efirst;
        string wtag, ptag;
        for (int i = 0; i < STEPS; i++) begin
            wcnt[i] = 0;
            wfirst[i] = -1;
        end
        hd  = f.hdl;
        vd  = f.vdl;
        cmb = f.cmb;
        for (int l = 0; l < int'(f.nl); l++) begin
            for (int s = 0; s < STEPS; s++) begin
                step(l, s, (s == 0),
                     (s == 2 * int'(f.vst)) &&
                     (l == 0 || (f.noise != 0 && l == int'(f.noise))));
            end
        end
        fl     = f.std ? F525 : F625;
        nw     = f.std ? N525 : N625;
        efirst = 2 * (HB + int'(f.hdl));
        for (int l = 1; l < int'(f.nl); l++) begin
            if (wcnt[l] != (((l >= fl) && (l < fl + nw)) ? 2 * WW : 0)) bad++;
            else if ((l >= fl) && (l < fl + nw) && (wfirst[l] != efirst)) bad++;
        end
        if (f.noise != 0)    wtag = $sformatf("R5 window after ignored pulse, field %0d", idx);
        else if (f.hdl != 0) wtag = $sformatf("R3 shifted window, field %0d", idx);
        else if (idx == 12)  wtag = $sformatf("R7 forced-standard window, field %0d", idx);
        else                 wtag = $sformatf("R2/R4 window lines and ticks, field %0d", idx);
        if (f.cmb || f.vdl != 0 || f.hdl != 0) ptag = $sformatf("R8 delayed reference parity, field %0d", idx);
        else                                   ptag = $sformatf("R9 field parity, field %0d", idx);
        chk(wtag, bad, 0);
        chk($sformatf("R6 line standard, field %0d", idx), int'(std525), int'(f.std));
        chk(ptag, int'(fodd), int'(f.par));
    endtask

    fld_t forced_f;

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R1 watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; ce = 1'b0; hs = 1'b0; vs = 1'b0; cmb = 1'b0;
        auto_en = 1'b1; force525 = 1'b0; gain_reg = 1'b0;
        hd = '0; vd = '0; sys = 2'b00;
        repeat (4) @(negedge clk);
        chk("R1 window in reset", int'(win), 0);
        chk("R1 standard in reset", int'(std525), 0);
        chk("R1 parity in reset", int'(fodd), 0);
        rst_n = 1'b1;
        for (int s = 1; s < 40; s++) step(0, s, 1'b0, 1'b0);
        chk("R1 no window before reference", int'(win), 0);

        for (int e = 0; e < 12; e++) run_field(FIELDS[e], e);

        // R7: forced standard overrides detection
        auto_en  = 1'b0;
        force525 = 1'b1;
        #1;
        chk("R7 forced 525", int'(std525), 1);
        forced_f = '{nl: 6'd31, vst: 6'd5, noise: 6'd0, hdl: 8'd0, vdl: 8'd0,
                     cmb: 1'b0, std: 1'b1, par: 1'b0};
        run_field(forced_f, 12);
        force525 = 1'b0;
        #1;
        chk("R7 forced 625", int'(std525), 0);
        auto_en = 1'b1;
        #1;
        chk("R7 auto restores detected 625", int'(std525), 0);

        // R10: chroma gain select
        sys = 2'b10; gain_reg = 1'b0; #1;
        chk("R10 SECAM code gives gain", int'(gain), 1);
        sys = 2'b00; #1;
        chk("R10 PAL code no gain", int'(gain), 0);
        sys = 2'b01; #1;
        chk("R10 NTSC code no gain", int'(gain), 0);
        sys = 2'b11; #1;
        chk("R10 unused code no gain", int'(gain), 0);
        sys = 2'b00; gain_reg = 1'b1; #1;
        chk("R10 register bit gives gain", int'(gain), 1);

        // R1: reset in the middle of a run
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 window after mid-run reset", int'(win), 0);
        chk("R1 standard after mid-run reset", int'(std525), 0);
        chk("R1 parity after mid-run reset", int'(fodd), 0);
        rst_n = 1'b1;

        done = 1'b1;
        summary();
        $finish;
    end

endmodule